// File: doc/BRIEF.md
# Ripple Bit-Slice Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit for a single-cycle execute stage. It is assembled from one-bit slices that are replicated across the operand width. Each slice forms the AND, the OR and the full-adder sum of its operand bits at the same time. A four-way select then picks which of these three values, or a fourth "less" input, drives that bit of the result. Carries pass in series from the least significant slice to the most significant one.

A single negate control does two jobs: it inverts the second operand in every slice, and it forces the carry into the lowest slice to one. Subtraction and the comparison both use this control. For set-less-than, the adder output of the top slice is fed back into the less input of bit 0, and every other bit's less input is tied to zero. A branch unit tests equality by requesting a subtraction and looking at the zero flag. The carry and signed-overflow flags describe the adder, and the adder runs for every operation.

Top module: `bsalu_top`

## Requirements
- R1: With neg_i=0 and op_i=00 the result is the bitwise AND of the two operands.
- R2: With neg_i=0 and op_i=01 the result is the bitwise OR of the two operands.
- R3: With neg_i=0 and op_i=10 the result is (a+b) mod 2^W, and carry_o is bit W of the full unsigned sum.
- R4: With neg_i=1 and op_i=10 the result is (a-b) mod 2^W, formed as a + NOT b + 1. carry_o is the carry out of the top bit of that sum, so it is 1 exactly when a >= b as unsigned numbers.
- R5: With neg_i=1 and op_i=11, result bits W-1 down to 1 are zero, and bit 0 equals the top bit of (a-b) mod 2^W, which is the raw sign of the wrapped difference.
- R6: For every operation, zero_o is 1 if and only if every result bit is 0.
- R7: ovf_o is the XOR of the carry into the top bit and the carry out of the top bit. For an add, it is set exactly when both operands have the same sign and the sign of the result differs from theirs. For a subtract, it is set exactly when the operands differ in sign and the sign of the result differs from the sign of a.
- R8: With neg_i=1 and op_i=10, zero_o is 1 if and only if a equals b.
- R9: neg_i inverts b under every select, so op_i=00 gives a AND NOT b and op_i=01 gives a OR NOT b. carry_o and ovf_o always describe the adder a + (b XOR neg) + neg, whatever op_i selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| neg_i | input | 1 | Invert b in every slice and force carry-in of bit 0 to 1 |
| op_i | input | 2 | Result select: 00 AND, 01 OR, 10 adder sum, 11 less |
| result_o | output | W | Selected result |
| zero_o | output | 1 | High when every result bit is 0 |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Signed overflow of the adder |

## Verification
The bench builds the block at its default width of 32 bits. At this width the signed limits 0x7FFFFFFF and 0x80000000 and the all-ones word can be applied directly, so the full carry chain runs end to end and each overflow direction is hit on both add and subtract. The directed cases include equal operands, which exercise the zero and equality paths, and a comparison where the difference wraps, which confirms that the less output follows the raw sign bit. Random operands under each of the eight control combinations exercise the inverted-b logic paths and confirm that the flags keep describing the adder whatever the result select picks.

// File: rtl/bsalu_pkg.sv
`timescale 1ns/1ps
package bsalu_pkg;
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } sel_e;
endpackage

// File: rtl/bsalu_slice.sv
`timescale 1ns/1ps
module bsalu_slice
   import bsalu_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   input  logic binv_i,
   input  logic cin_i,
   input  logic less_i,
   input  sel_e sel_i,
   output logic res_o,
   output logic cout_o,
   output logic sum_o
);
   logic bb;

   // operand b after optional inversion
   assign bb     = b_i ^ binv_i;
   assign sum_o  = a_i ^ bb ^ cin_i;
   assign cout_o = (a_i & bb) | (a_i & cin_i) | (bb & cin_i);

   always_comb begin
      case (sel_i)
         SEL_AND:  res_o = a_i & bb;
         SEL_OR:   res_o = a_i | bb;
         SEL_SUM:  res_o = sum_o;
         default:  res_o = less_i;
      endcase
   end
endmodule

// File: rtl/bsalu_opdec.sv
`timescale 1ns/1ps
module bsalu_opdec
   import bsalu_pkg::*;
(
   input  logic       neg_i,
   input  logic [1:0] op_i,
   output logic       binv_o,
   output logic       cin0_o,
   output sel_e       sel_o
);
   // one control line feeds both the inversion and the lowest carry
   assign binv_o = neg_i;
   assign cin0_o = neg_i;
   assign sel_o  = sel_e'(op_i);
endmodule

// File: rtl/bsalu_flags.sv
`timescale 1ns/1ps
module bsalu_flags #(
   parameter int W = 32
) (
   input  logic [W-1:0] res_i,
   input  logic         msb_cin_i,
   input  logic         msb_cout_i,
   output logic         zero_o,
   output logic         carry_o,
   output logic         ovf_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("bsalu_flags: W must be at least 2");
      end
   endgenerate

   assign zero_o  = ~(|res_i);
   assign carry_o = msb_cout_i;
   assign ovf_o   = msb_cin_i ^ msb_cout_i;
endmodule

// File: rtl/bsalu_top.sv
`timescale 1ns/1ps
module bsalu_top
   import bsalu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         neg_i,
   input  logic [1:0]   op_i,
   output logic [W-1:0] result_o,
   output logic         zero_o,
   output logic         carry_o,
   output logic         ovf_o
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("bsalu_top: W must be at least 2");
      end
   endgenerate

   logic binv;
   logic cin0;
   sel_e sel;
   logic msb_sum;
   logic msb_cin;
   logic msb_cout;

   bsalu_opdec u_dec (
      .neg_i  (neg_i),
      .op_i   (op_i),
      .binv_o (binv),
      .cin0_o (cin0),
      .sel_o  (sel)
   );

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic ci;
         logic co;
         logic sm;
         logic lss;
         logic rb;

         if (i == 0) begin : g_lsb
            assign ci  = cin0;
            assign lss = msb_sum;
         end else begin : g_upper
            assign ci  = g_bit[i-1].co;
            assign lss = 1'b0;
         end

         bsalu_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .binv_i (binv),
            .cin_i  (ci),
            .less_i (lss),
            .sel_i  (sel),
            .res_o  (rb),
            .cout_o (co),
            .sum_o  (sm)
         );

         assign result_o[i] = rb;
      end
   endgenerate

   assign msb_sum  = g_bit[MSB].sm;
   assign msb_cin  = g_bit[MSB].ci;
   assign msb_cout = g_bit[MSB].co;

   bsalu_flags #(.W(W)) u_flags (
      .res_i      (result_o),
      .msb_cin_i  (msb_cin),
      .msb_cout_i (msb_cout),
      .zero_o     (zero_o),
      .carry_o    (carry_o),
      .ovf_o      (ovf_o)
   );
endmodule

// File: rtl/bsalu_chk.sv
`timescale 1ns/1ps
module bsalu_chk #(
   parameter int W = 32
) (
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic         neg_i,
   input logic [1:0]   op_i,
   input logic [W-1:0] result_o,
   input logic         zero_o,
   input logic         carry_o,
   input logic         ovf_o
);
   localparam int M = W - 1;
   logic [W:0] wide_add;

   assign wide_add = {1'b0, a_i} + {1'b0, b_i};

   always_comb begin
      if (!neg_i && op_i == 2'b00)
         p_and_r1: assert (result_o == (a_i & b_i)) else $error("p_and_r1");
      if (neg_i && op_i == 2'b00)
         p_andn_r9: assert (result_o == (a_i & ~b_i)) else $error("p_andn_r9");
      if (!neg_i && op_i == 2'b10)
         p_carry_add_r3: assert (carry_o == wide_add[W]) else $error("p_carry_add_r3");
      if (neg_i && op_i == 2'b10)
         p_carry_sub_r4: assert (carry_o == (a_i >= b_i)) else $error("p_carry_sub_r4");
      if (neg_i && op_i == 2'b11)
         p_less_hi_r5: assert (result_o[M:1] == '0) else $error("p_less_hi_r5");
      p_zero_r6: assert (zero_o == (result_o == '0)) else $error("p_zero_r6");
      if (!neg_i && op_i == 2'b10)
         p_ovf_add_r7: assert (ovf_o == ((a_i[M] == b_i[M]) && (result_o[M] != a_i[M])))
            else $error("p_ovf_add_r7");
      if (neg_i && op_i == 2'b10)
         p_ovf_sub_r7: assert (ovf_o == ((a_i[M] != b_i[M]) && (result_o[M] != a_i[M])))
            else $error("p_ovf_sub_r7");
      if (neg_i && op_i == 2'b10)
         p_eq_r8: assert (zero_o == (a_i == b_i)) else $error("p_eq_r8");
   end
endmodule

bind bsalu_top bsalu_chk #(.W(W)) u_chk (
   .a_i      (a_i),
   .b_i      (b_i),
   .neg_i    (neg_i),
   .op_i     (op_i),
   .result_o (result_o),
   .zero_o   (zero_o),
   .carry_o  (carry_o),
   .ovf_o    (ovf_o)
);

// File: tb/bsalu_top_tb_top.sv
`timescale 1ns/1ps
module bsalu_top_tb_top;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [W-1:0] a, b, res;
   logic         neg;
   logic [1:0]   op;
   logic         zf, cf, vf;

   bsalu_top #(.W(W)) dut_i (
      .a_i(a), .b_i(b), .neg_i(neg), .op_i(op),
      .result_o(res), .zero_o(zf), .carry_o(cf), .ovf_o(vf)
   );

   typedef struct {
      logic [W-1:0] r;
      logic z, c, v;
      string tag;
   } exp_t;

   exp_t q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // independent model built from the requirements
   function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic n, input logic [1:0] s, input string t);
      exp_t e;
      logic [W-1:0] yb;
      logic [W:0]   sum;
      yb  = n ? ~y : y;
      sum = {1'b0, x} + {1'b0, yb} + {{W{1'b0}}, n};
      case (s)
         2'b00:   e.r = x & yb;
         2'b01:   e.r = x | yb;
         2'b10:   e.r = sum[W-1:0];
         default: e.r = {{(W-1){1'b0}}, sum[W-1]};
      endcase
      e.z   = (e.r == '0);
      e.c   = sum[W];
      e.v   = (x[W-1] == yb[W-1]) && (sum[W-1] != x[W-1]);
      e.tag = t;
      return e;
   endfunction

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic n, input logic [1:0] s, input string t);
      @(posedge clk);
      a = x; b = y; neg = n; op = s;
      q.push_back(model(x, y, n, s, t));
   endtask

   // monitor: sample half a period after inputs change
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (res !== e.r || zf !== e.z || cf !== e.c || vf !== e.v) begin
               n_fail++;
               $display("FAIL %s a=%h b=%h neg=%b op=%b : got r=%h z=%b c=%b v=%b exp r=%h z=%b c=%b v=%b",
                        e.tag, a, b, neg, op, res, zf, cf, vf, e.r, e.z, e.c, e.v);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; neg = 1'b0; op = 2'b00;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // idle state: all-zero inputs give zero result, zero flag set (R6)
      drive('0, '0, 1'b0, 2'b00, "R6");
      // R1 / R2 logic ops
      drive(32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 2'b00, "R1");
      drive(32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b0, 2'b00, "R1");
      drive(32'hF0F0_0000, 32'h00FF_00FF, 1'b0, 2'b01, "R2");
      // R3 add boundaries
      drive(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b10, "R3");
      drive(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b10, "R3");
      drive(32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10, "R7");
      // R4 subtract
      drive(32'd5, 32'd3, 1'b1, 2'b10, "R4");
      drive(32'd3, 32'd5, 1'b1, 2'b10, "R4");
      drive(32'h8000_0000, 32'h1, 1'b1, 2'b10, "R7");
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b10, "R7");
      // R5 set-less-than, including a wrapping difference
      drive(32'd3, 32'd5, 1'b1, 2'b11, "R5");
      drive(32'd5, 32'd3, 1'b1, 2'b11, "R5");
      drive(32'hFFFF_FFFF, 32'h1, 1'b1, 2'b11, "R5");
      drive(32'h8000_0000, 32'h1, 1'b1, 2'b11, "R5");
      drive(32'h1234_5678, 32'h1234_5678, 1'b1, 2'b11, "R5");
      // R8 equality via subtract
      drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 2'b10, "R8");
      drive(32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b1, 2'b10, "R8");
      drive(32'h8000_0000, 32'h8000_0000, 1'b1, 2'b10, "R8");
      // R9 inverted b under logic selects, flags from adder
      drive(32'hFFFF_0000, 32'hF0F0_F0F0, 1'b1, 2'b00, "R9");
      drive(32'h0000_0000, 32'hF0F0_F0F0, 1'b1, 2'b01, "R9");
      drive(32'h7FFF_FFFF, 32'h1, 1'b0, 2'b00, "R9");
      drive(32'hFFFF_FFFF, 32'h1, 1'b0, 2'b01, "R9");
      // random operands for every control combination
      for (int k = 0; k < 8; k++) begin
         for (int j = 0; j < 40; j++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = (j % 8 == 0) ? x : $urandom();
            drive(x, y, k[2], k[1:0], (k == 2) ? "R3" : (k == 6) ? "R4" :
                  (k == 7) ? "R5" : (k == 0) ? "R1" : (k == 1) ? "R2" : "R9");
         end
      end
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule